// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block arbitrates eight interrupt request lines for a processor. Software sets it up through an ordered series of initialization words written to two register addresses, A and B. It then masks individual lines, and it raises a single interrupt output whenever an unmasked pending request outranks every level currently being serviced. When the processor acknowledges, the block returns an 8-bit vector formed from a programmed base and the winning line number. It then records that line as in service until software retires it with an end-of-interrupt command.

Triggering can be edge or level. Retirement can be explicit or automatic at acknowledge time. Priority is fixed with line 0 highest by default, but software can rotate it so that the most recently served level drops to the bottom. The cascade map from the initialization sequence is held and driven out for the surrounding logic. Only one controller is modelled.

Top module: `pic8_core`

## Requirements
- R1: After reset, `int_out`, `ready`, `vec_valid` and `in_service` are all zero.
- R2: A write to address A (`addr`=0) with data bit 4 set starts initialization and clears mask, request and in-service state. In that word, bit 0=1 means a fourth word follows, bit 1=1 means single (no third word), and bit 3=1 means level triggering. The later words go to address B in order: base, cascade map (only when bit 1 was 0), then mode word (only when bit 0 was 1). `ready` rises after the last expected word. The cascade map appears on `cascade_cfg`.
- R3: One cycle after an `inta` pulse, `vec_valid` is high for one cycle, and `vector` is the base (second word bits 7:3) in bits 7:3 with the winning line in bits 2:0.
- R4: Once ready, a write to address B loads the mask. A set bit keeps its line from raising `int_out`. A pending request on that line is kept and is served once the line is unmasked.
- R5: By default line 0 has the highest priority and line 7 the lowest. `int_out` is high only when an unmasked pending line outranks every in-service level. On acknowledge, the winner's `in_service` bit is set.
- R6: An operation write to address A with bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit. With bits 7:5 = 011 it clears the bit named by bits 2:0.
- R7: When bit 1 of the mode word is set, acknowledge does not set any `in_service` bit.
- R8: With bits 7:5 = 101, the highest in-service bit is cleared and that level becomes the lowest priority. With 111, the named level is cleared and becomes the lowest priority. With 110, the named level becomes the lowest priority and nothing is cleared.
- R9: In edge mode, a rising edge is latched, so a one-cycle pulse stays pending. In level mode, the request follows the input, and `int_out` falls when the input drops before acknowledge.
- R10: An acknowledge with nothing pending returns the base with line 7 and changes no in-service state.
- R11: When bit 4 of the mode word is set, a request at the same level as the highest in-service level also raises `int_out`.
- R12: A write to address A with bit 4 clear and bit 3 set has no effect on in-service state. A write to address B before initialization does not make the block ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register address: 0 = A, 1 = B |
| wr_data | input | 8 | Write data |
| irq_in | input | 8 | Request lines |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking `vector` as new |
| ready | output | 1 | Initialization complete |
| in_service | output | 8 | In-service register |
| cascade_cfg | output | 8 | Cascade map from the third initialization word |

## Verification
The hardest states to reach are those where rotated priority and nested service interact. Examples are a request that outranks line 0 only because line 0 was just served with rotation, or a second request at an equal level that fires only under the nested-mode bit. The stimulus reaches these states by scripted sequences: it serves one line, retires it with a rotating end-of-interrupt, then presents pairs of lines whose winner reverses under the new order. A scoreboard queue records each expected vector at acknowledge time and compares it when the strobe appears. Several re-initializations walk every path through the optional third and fourth words.

// File: rtl/pic8_core.sv
module pic8_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] irq_in,
  input  logic       inta,
  output logic       int_out,
  output logic [7:0] vector,
  output logic       vec_valid,
  output logic       ready,
  output logic [7:0] in_service,
  output logic [7:0] cascade_cfg
);
  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CASC, S_MODE, S_RUN} st_t;

  st_t        st;
  logic [7:0] irr, isr, imr, casc, prev;
  logic [4:0] base;
  logic [2:0] low;
  logic       level_m, single_m, need_mode, aeoi, nested, rot_auto;

  logic       win_any, top_any;
  logic [2:0] win, win_rk, top, top_rk;
  logic [7:0] req;

  assign req = irr & ~imr;

  always_comb begin
    logic [2:0] idx;
    win_any = 1'b0; win = '0; win_rk = '0;
    top_any = 1'b0; top = '0; top_rk = '0;
    for (int k = 7; k >= 0; k--) begin
      idx = low + 3'(k) + 3'd1;
      if (req[idx]) begin win_any = 1'b1; win = idx; win_rk = 3'(k); end
      if (isr[idx]) begin top_any = 1'b1; top = idx; top_rk = 3'(k); end
    end
  end

  wire icw1 = wr_en && !addr && wr_data[4];
  wire ocw2 = wr_en && !addr && !wr_data[4] && !wr_data[3] && st == S_RUN;
  wire ack  = inta && st == S_RUN;
  wire [2:0] lvl = wr_data[2:0];

  assign int_out = st == S_RUN && win_any &&
                   (!top_any || win_rk < top_rk || (nested && win_rk == top_rk));
  assign ready       = st == S_RUN;
  assign in_service  = isr;
  assign cascade_cfg = casc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      irr <= '0; isr <= '0; imr <= '1; casc <= '0; prev <= '0;
      base <= '0; low <= 3'd7;
      level_m <= 1'b0; single_m <= 1'b0; need_mode <= 1'b0;
      aeoi <= 1'b0; nested <= 1'b0; rot_auto <= 1'b0;
      vector <= '0; vec_valid <= 1'b0;
    end else begin
      vec_valid <= 1'b0;
      prev <= irq_in;
      if (level_m) irr <= irq_in;
      else         irr <= irr | (irq_in & ~prev);

      if (ack) begin
        vec_valid <= 1'b1;
        vector <= {base, win_any ? win : 3'd7};
        if (win_any) begin
          irr[win] <= 1'b0;
          if (!aeoi)         isr[win] <= 1'b1;
          else if (rot_auto) low <= win;
        end
      end

      if (icw1) begin
        st <= S_BASE;
        need_mode <= wr_data[0];
        single_m  <= wr_data[1];
        level_m   <= wr_data[3];
        irr <= '0; isr <= '0; imr <= '0; casc <= '0;
        low <= 3'd7; aeoi <= 1'b0; nested <= 1'b0; rot_auto <= 1'b0;
      end else if (wr_en && addr) begin
        case (st)
          S_BASE: begin
            base <= wr_data[7:3];
            st <= !single_m ? S_CASC : (need_mode ? S_MODE : S_RUN);
          end
          S_CASC: begin
            casc <= wr_data;
            st <= need_mode ? S_MODE : S_RUN;
          end
          S_MODE: begin
            aeoi   <= wr_data[1];
            nested <= wr_data[4];
            st <= S_RUN;
          end
          S_RUN:   imr <= wr_data;
          default: ;
        endcase
      end else if (ocw2) begin
        case (wr_data[7:5])
          3'b001: if (top_any) isr[top] <= 1'b0;
          3'b011: isr[lvl] <= 1'b0;
          3'b101: if (top_any) begin isr[top] <= 1'b0; low <= top; end
          3'b111: begin isr[lvl] <= 1'b0; low <= lvl; end
          3'b110: low <= lvl;
          3'b100: rot_auto <= 1'b1;
          3'b000: rot_auto <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  // R2: starting initialization drops ready and empties service state
  a_r2_init_restart: assert property (@(posedge clk) disable iff (!rst_n)
    icw1 |=> !ready && in_service == 8'h00);

  // R3: each vector carries the programmed base
  a_r3_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vector[7:3] == base);

  // R4: mask writes after initialization land in the mask register
  a_r4_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr && ready |=> imr == $past(wr_data));

  // R5: a served interrupt adds exactly one in-service bit
  a_r5_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    inta && int_out && !aeoi && !nested && !wr_en
      |=> $countones(isr) == $countones($past(isr)) + 1);

  // R7: automatic retirement leaves in-service untouched
  a_r7_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    inta && ready && aeoi && !wr_en |=> $stable(isr));
endmodule

// File: tb/tb_pic8_core.sv
module tb_pic8_core;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0;
  logic       int_out, vec_valid, ready;
  logic [7:0] vector, in_service, cascade_cfg;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  pic8_core dut (.clk, .rst_n, .wr_en, .addr, .wr_data, .irq_in, .inta,
                 .int_out, .vector, .vec_valid, .ready, .in_service, .cascade_cfg);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drive(logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(logic [7:0] exp);
    @(negedge clk); inta = 1'b1; expq.push_back(exp);
    @(negedge clk); inta = 1'b0;
  endtask

  // monitor: compares each delivered vector with the scoreboard (R3)
  always @(negedge clk) begin
    if (vec_valid) begin
      if (expq.size() == 0) chk("R3 unexpected vector", vector, 8'hxx);
      else chk("R3 vector", vector, expq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 ready", {7'd0, ready}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    chk("R1 in_service", in_service, 8'h00);
    rst_n = 1'b1; tick();

    wr(1'b1, 8'h55);
    chk("R12 port B before init", {7'd0, ready}, 8'h00);

    // single, edge, mode word follows; base 0x40
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h40);
    chk("R2 not ready before mode word", {7'd0, ready}, 8'h00);
    wr(1'b1, 8'h01);
    chk("R2 ready", {7'd0, ready}, 8'h01);
    chk("R2 no cascade map", cascade_cfg, 8'h00);

    drive(8'h28);
    chk("R5 int raised", {7'd0, int_out}, 8'h01);
    ack(8'h43);
    chk("R5 isr line 3", in_service, 8'h08);
    chk("R5 lower line blocked", {7'd0, int_out}, 8'h00);
    drive(8'h2A);
    chk("R5 higher line nests", {7'd0, int_out}, 8'h01);
    ack(8'h41);
    chk("R5 nested isr", in_service, 8'h0A);
    wr(1'b0, 8'h20);
    chk("R6 nonspecific eoi", in_service, 8'h08);
    chk("R6 still blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h63);
    chk("R6 specific eoi", in_service, 8'h00);
    chk("R6 line 5 now raises", {7'd0, int_out}, 8'h01);
    ack(8'h45);
    wr(1'b0, 8'h28);
    chk("R12 bit3 write ignored", in_service, 8'h20);
    wr(1'b0, 8'h20);
    drive(8'h00);

    drive(8'h40); drive(8'h00);
    chk("R9 edge pulse latched", {7'd0, int_out}, 8'h01);
    ack(8'h46);
    wr(1'b0, 8'h20);

    wr(1'b1, 8'h04);
    drive(8'h04);
    chk("R4 masked line silent", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R4 unmask releases", {7'd0, int_out}, 8'h01);
    ack(8'h42);
    wr(1'b0, 8'h20);
    drive(8'h00);

    ack(8'h47);
    chk("R10 spurious keeps isr", in_service, 8'h00);

    drive(8'h01);
    ack(8'h40);
    wr(1'b0, 8'hA0);
    chk("R8 rotate eoi clears", in_service, 8'h00);
    drive(8'h00);
    drive(8'h05);
    ack(8'h42);
    wr(1'b0, 8'h20);
    ack(8'h40);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'hC4);
    drive(8'h00);
    drive(8'h30);
    ack(8'h45);
    wr(1'b0, 8'hE5);
    chk("R8 specific rotate clears", in_service, 8'h00);
    ack(8'h44);
    wr(1'b0, 8'h20);
    drive(8'h00);

    // level mode, base 0x80
    wr(1'b0, 8'h1B); wr(1'b1, 8'h80); wr(1'b1, 8'h01);
    drive(8'h10);
    chk("R9 level raises", {7'd0, int_out}, 8'h01);
    drive(8'h00);
    chk("R9 level drop clears", {7'd0, int_out}, 8'h00);
    drive(8'h10);
    ack(8'h84);
    wr(1'b0, 8'h64);
    drive(8'h00);

    // cascaded, automatic retirement, base 0xA0
    wr(1'b0, 8'h11); wr(1'b1, 8'hA0);
    chk("R2 waits for cascade map", {7'd0, ready}, 8'h00);
    wr(1'b1, 8'h84);
    chk("R2 cascade map", cascade_cfg, 8'h84);
    chk("R2 waits for mode word", {7'd0, ready}, 8'h00);
    wr(1'b1, 8'h03);
    drive(8'h08);
    ack(8'hA3);
    chk("R7 aeoi no isr", in_service, 8'h00);
    drive(8'h00);

    // cascaded, nested mode
    wr(1'b0, 8'h11); wr(1'b1, 8'hA0); wr(1'b1, 8'h00); wr(1'b1, 8'h11);
    drive(8'h08);
    ack(8'hA3);
    drive(8'h00); drive(8'h08);
    chk("R11 equal level raises", {7'd0, int_out}, 8'h01);
    drive(8'h00);

    // single, no mode word, base 0x60
    wr(1'b0, 8'h12); wr(1'b1, 8'h60);
    chk("R2 ready without optional words", {7'd0, ready}, 8'h01);
    drive(8'h01);
    ack(8'h60);

    repeat (3) tick();
    chk("R3 scoreboard drained", 8'(expq.size()), 8'h00);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule